// File: doc/BRIEF.md
# Frame-Pulse Polarity Detector and Serial Bit Timer

This block is the timing front end of a time-division serial port. It watches a 4.096 MHz bit clock and a frame pulse, both oversampled in a faster system clock domain. One 2.048 Mb/s bit spans two bit-clock periods, which is four bit-clock edges. A frame holds 256 bits in 32 channels of 8 bits. The block works out whether the backplane marks frames with a short low-going pulse or a short high-going pulse. From that choice it sets which bit-clock edge opens a bit and which edge samples incoming data.

Once the polarity is confirmed and the timing is aligned, the block produces three single-cycle strobes in the system domain: a bit-boundary strobe for the transmitters, a sampling strobe for the receivers, and a frame-start strobe. It also drives a channel index and a bit-in-channel index. All of these pins are plain control and status signals. There is no data stream and no valid/ready handshake, so back-pressure does not apply. Every strobe comes three system clocks after the bit-clock edge that causes it: two synchronizer stages plus one output register.

Top module: `fp_bit_timer`

## Requirements
- R1: After reset, lock_valid, mode_gci, tx_bnd_en, sample_en and frame_start are 0, and chan_idx and bit_idx are 0.
- R2: The frame pulse is sampled on each rising bit-clock edge. A low-going pulse means the line idles high and is low for 1 to 4 samples. When such pulses end exactly 512 rising edges apart twice in a row, mode_gci is 0. lock_valid then goes to 1 at the rising edge where the next pulse is first sampled low, and not earlier.
- R3: A high-going pulse (idle low, high for 1 to 4 samples) with the same spacing gives mode_gci = 1 and lock_valid = 1. mode_gci stays constant while lock_valid is 1.
- R4: With mode_gci = 0, tx_bnd_en pulses once every 4 bit-clock edges and only after falling edges. sample_en pulses only after rising edges, exactly 3 edges after each boundary, which is three quarters of the way into the bit.
- R5: With mode_gci = 1, tx_bnd_en pulses once every 4 edges and only after rising edges. sample_en pulses only after falling edges, 3 edges after each boundary.
- R6: Pulses whose spacing is not 512 rising edges never set lock_valid.
- R7: A pulse that stays active for more than 4 samples is not treated as a frame pulse and never sets lock_valid.
- R8: If no valid pulse of the locked polarity ends within 1024 rising edges, lock_valid drops to 0. Detection then starts over, and two new pulses at the correct spacing are needed before lock_valid returns to 1.
- R9: frame_start lasts one system clock and coincides with tx_bnd_en while chan_idx = 0 and bit_idx = 0. It falls on the first boundary-type edge after the rising edge that first samples the pulse active. Consecutive frame starts are 1024 edges apart. At each boundary, the value chan_idx*8 + bit_idx goes up by one, modulo 256.
- R10: tx_bnd_en, sample_en and frame_start stay 0 while no lock is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | 4.096 MHz bit clock, asynchronous |
| fp_in | input | 1 | Frame pulse, either polarity, asynchronous |
| mode_gci | output | 1 | 0 = low-going frame pulse, 1 = high-going frame pulse |
| lock_valid | output | 1 | Polarity confirmed and timing aligned |
| tx_bnd_en | output | 1 | One-clock strobe at each bit boundary |
| sample_en | output | 1 | One-clock strobe at the data sampling point |
| frame_start | output | 1 | One-clock strobe at the first boundary of a frame |
| chan_idx | output | 5 | Channel number within the frame |
| bit_idx | output | 3 | Bit number within the channel |

## Verification
The main function is tried with four frame-pulse patterns. Short low-going pulses and short high-going pulses, both at the correct spacing, show whether the block picks the right polarity and the matching pair of boundary and sampling edges. Short pulses at the wrong spacing, and correctly spaced pulses that are too wide, show that the lock depends on both rules and not on any periodic transition. Stopping and restarting the pulses after a lock shows the two-frame timeout, and that a fresh confirmation is needed before lock_valid returns.

// File: rtl/fpt_pkg.sv
package fpt_pkg;
  typedef enum logic {
    FP_ACT_LOW  = 1'b0,
    FP_ACT_HIGH = 1'b1
  } fp_pol_e;
endpackage

// File: rtl/fpt_edge_sync.sv
module fpt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fp_in,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic fp_lvl
);
  logic [STAGES-1:0] bsh, fsh;
  logic              b_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsh <= '0;
      fsh <= '0;
      b_d <= 1'b0;
    end else begin
      bsh <= {bsh[STAGES-2:0], bclk_in};
      fsh <= {fsh[STAGES-2:0], fp_in};
      b_d <= bsh[STAGES-1];
    end
  end

  assign bclk_rise = bsh[STAGES-1] & ~b_d;
  assign bclk_fall = ~bsh[STAGES-1] & b_d;
  assign fp_lvl    = fsh[STAGES-1];
endmodule

// File: rtl/fpt_detect.sv
module fpt_detect
  import fpt_pkg::*;
#(
  parameter int FRAME_PER = 512,
  parameter int PW_MAX    = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rise,
  input  logic    fp_lvl,
  output fp_pol_e pol,
  output logic    valid,
  output logic    resync
);
  localparam int GAP_W = $clog2(2 * FRAME_PER + 1);
  localparam int RUN_W = $clog2(PW_MAX + 2);
  localparam logic [GAP_W-1:0] GAP_LIM   = GAP_W'(2 * FRAME_PER);
  localparam logic [GAP_W-1:0] GAP_MATCH = GAP_W'(FRAME_PER);
  localparam logic [RUN_W-1:0] RUN_SAT   = RUN_W'(PW_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_OK    = RUN_W'(PW_MAX);

  logic             lvl, have_prev, prev_pol, locked;
  logic [RUN_W-1:0] run;
  logic [GAP_W-1:0] gap, gap_inc;
  logic             chg, qual_end;
  fp_pol_e          pol_q;

  assign chg      = rise && (fp_lvl != lvl);
  assign qual_end = chg && (run <= RUN_OK);
  assign gap_inc  = (gap == GAP_LIM) ? GAP_LIM : gap + 1'b1;
  assign resync   = chg && locked && (fp_lvl == logic'(pol_q));
  assign pol      = pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl       <= 1'b0;
      run       <= RUN_SAT;
      gap       <= '0;
      have_prev <= 1'b0;
      prev_pol  <= 1'b0;
      locked    <= 1'b0;
      pol_q     <= FP_ACT_LOW;
      valid     <= 1'b0;
    end else if (rise) begin
      lvl <= fp_lvl;
      run <= chg ? RUN_W'(1) : ((run == RUN_SAT) ? RUN_SAT : run + 1'b1);
      if (!locked) begin
        if (qual_end) begin
          if (have_prev && prev_pol == lvl && gap_inc == GAP_MATCH) begin
            locked <= 1'b1;
            pol_q  <= fp_pol_e'(lvl);
          end
          have_prev <= 1'b1;
          prev_pol  <= lvl;
          gap       <= '0;
        end else begin
          gap <= gap_inc;
          if (gap_inc == GAP_LIM) have_prev <= 1'b0;
        end
      end else begin
        if (resync) valid <= 1'b1;
        if (qual_end && lvl == logic'(pol_q)) begin
          gap <= '0;
        end else if (gap_inc == GAP_LIM) begin
          locked    <= 1'b0;
          valid     <= 1'b0;
          have_prev <= 1'b0;
          gap       <= '0;
        end else begin
          gap <= gap_inc;
        end
      end
    end
  end

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n) valid |-> locked); // R2
  AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) gap <= GAP_LIM); // R8
  AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n) (locked && $past(locked)) |-> $stable(pol_q)); // R3
  AST_VALID_ON_RESYNC: assert property (@(posedge clk) disable iff (!rst_n) $rose(valid) |-> $past(resync)); // R2
endmodule

// File: rtl/fpt_bit_timer.sv
module fpt_bit_timer
  import fpt_pkg::*;
#(
  parameter int FRAME_BITS  = 256,
  parameter int BITS_PER_CH = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rise,
  input  logic    fall,
  input  logic    resync,
  input  fp_pol_e pol,
  input  logic    valid,
  output logic    tx_bnd_en,
  output logic    sample_en,
  output logic    frame_start,
  output logic [$clog2(FRAME_BITS/BITS_PER_CH)-1:0] chan_idx,
  output logic [$clog2(BITS_PER_CH)-1:0]            bit_idx
);
  localparam int EDGE_W = $clog2(FRAME_BITS * 4);
  localparam int CH_W   = $clog2(FRAME_BITS / BITS_PER_CH);
  localparam int BIT_W  = $clog2(BITS_PER_CH);
  localparam logic [EDGE_W-1:0] LAST = '1;

  logic [EDGE_W-1:0] e, e_nxt;
  logic              edge_ev;

  assign edge_ev = rise | fall;

  always_comb begin
    if (resync) e_nxt = (pol == FP_ACT_HIGH) ? LAST - 1'b1 : LAST;
    else        e_nxt = e + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e           <= '0;
      tx_bnd_en   <= 1'b0;
      sample_en   <= 1'b0;
      frame_start <= 1'b0;
    end else if (edge_ev) begin
      e           <= e_nxt;
      tx_bnd_en   <= valid && (e_nxt[1:0] == 2'd0);
      sample_en   <= valid && (e_nxt[1:0] == 2'd3);
      frame_start <= valid && (e_nxt == '0);
    end else begin
      tx_bnd_en   <= 1'b0;
      sample_en   <= 1'b0;
      frame_start <= 1'b0;
    end
  end

  assign chan_idx = e[EDGE_W-1 -: CH_W];
  assign bit_idx  = e[2 +: BIT_W];

  AST_TX_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) (tx_bnd_en && pol == FP_ACT_LOW) |-> $past(fall)); // R4
  AST_SMP_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n) (sample_en && pol == FP_ACT_LOW) |-> $past(rise)); // R4
  AST_TX_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n) (tx_bnd_en && pol == FP_ACT_HIGH) |-> $past(rise)); // R5
  AST_SMP_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) (sample_en && pol == FP_ACT_HIGH) |-> $past(fall)); // R5
  AST_FS_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n) frame_start |-> (tx_bnd_en && chan_idx == '0 && bit_idx == '0)); // R9
  AST_STROBE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (tx_bnd_en || sample_en || frame_start) |-> $past(valid)); // R10
endmodule

// File: rtl/fp_bit_timer.sv
module fp_bit_timer
  import fpt_pkg::*;
#(
  parameter int FRAME_BITS  = 256,
  parameter int BITS_PER_CH = 8,
  parameter int PW_MAX      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fp_in,
  output logic mode_gci,
  output logic lock_valid,
  output logic tx_bnd_en,
  output logic sample_en,
  output logic frame_start,
  output logic [$clog2(FRAME_BITS/BITS_PER_CH)-1:0] chan_idx,
  output logic [$clog2(BITS_PER_CH)-1:0]            bit_idx
);
  localparam int FRAME_PER = FRAME_BITS * 2;

  logic    rise, fall, fp_lvl, resync, valid;
  fp_pol_e pol;

  fpt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fp_in(fp_in),
    .bclk_rise(rise), .bclk_fall(fall), .fp_lvl(fp_lvl)
  );

  fpt_detect #(.FRAME_PER(FRAME_PER), .PW_MAX(PW_MAX)) u_det (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fp_lvl(fp_lvl),
    .pol(pol), .valid(valid), .resync(resync)
  );

  fpt_bit_timer #(.FRAME_BITS(FRAME_BITS), .BITS_PER_CH(BITS_PER_CH)) u_tmr (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .resync(resync),
    .pol(pol), .valid(valid), .tx_bnd_en(tx_bnd_en), .sample_en(sample_en),
    .frame_start(frame_start), .chan_idx(chan_idx), .bit_idx(bit_idx)
  );

  assign mode_gci   = (pol == FP_ACT_HIGH);
  assign lock_valid = valid;
endmodule

// File: tb/tb_fp_bit_timer.sv
module tb_fp_bit_timer;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_CLK  = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_in = 1'b0;
  logic fp_in = 1'b1;
  logic mode_gci, lock_valid, tx_bnd_en, sample_en, frame_start;
  logic [4:0] chan_idx;
  logic [2:0] bit_idx;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // generator controls
  bit gen_on = 0;
  bit gen_pol = 0;
  int gen_space = 512;
  int gen_width = 1;
  // generator state
  int gcnt = 4;
  int pc = 0;
  int edge_count = 0;
  bit last_fall = 0;

  fp_bit_timer dut (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fp_in(fp_in),
    .mode_gci(mode_gci), .lock_valid(lock_valid), .tx_bnd_en(tx_bnd_en),
    .sample_en(sample_en), .frame_start(frame_start),
    .chan_idx(chan_idx), .bit_idx(bit_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        gcnt = 4; pc = 0; edge_count = 0; bclk_in = 1'b0;
        fp_in = ~gen_pol;
      end else begin
        gcnt = (gcnt + 1) % 8;
        if (gcnt == 0) begin
          bclk_in = 1'b1; last_fall = 0; edge_count++;
        end else if (gcnt == 4) begin
          bclk_in = 1'b0; last_fall = 1; edge_count++;
          fp_in = (gen_on && pc < gen_width) ? gen_pol : ~gen_pol;
          pc = (pc + 1 >= gen_space) ? 0 : pc + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input bit pol, input int space, input int width);
    gen_pol = pol; gen_space = space; gen_width = width; gen_on = 0;
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (4) tick();
    rst_n = 1'b1;
    gen_on = 1;
  endtask

  task automatic wait_valid(input int max_cyc, output bit seen);
    seen = 0;
    for (int i = 0; i < max_cyc; i++) begin
      tick();
      if (lock_valid) begin seen = 1; break; end
    end
  endtask

  // R1
  task automatic t_reset();
    gen_pol = 0; gen_on = 0;
    @(posedge clk); #1; rst_n = 1'b0;
    repeat (3) tick();
    chk(lock_valid == 0, "R1 lock_valid", lock_valid, 0);
    chk(mode_gci == 0, "R1 mode_gci", mode_gci, 0);
    chk({tx_bnd_en, sample_en, frame_start} == 3'b000, "R1 strobes", {tx_bnd_en, sample_en, frame_start}, 0);
    chk(chan_idx == 0 && bit_idx == 0, "R1 counters", {chan_idx, bit_idx}, 0);
  endtask

  // R2 / R3 lock, then R4 / R5 / R9 timing
  task automatic t_lock(input bit pol);
    bit seen;
    do_reset(pol, 512, 1);
    repeat (FRAME_CLK + FRAME_CLK/2) tick();
    chk(lock_valid == 0, pol ? "R3 no early valid" : "R2 no early valid", lock_valid, 0);
    wait_valid(3 * FRAME_CLK, seen);
    chk(seen, pol ? "R3 valid set" : "R2 valid set", seen, 1);
    chk(mode_gci == pol, pol ? "R3 mode" : "R2 mode", mode_gci, pol);
    t_timing(pol);
  endtask

  task automatic t_timing(input bit pol);
    int last_tx_ec = 0, last_fs_ec = 0, last_pos = 0;
    bit have_tx = 0, have_fs = 0;
    string rq;
    rq = pol ? "R5" : "R4";
    for (int i = 0; i < 5200; i++) begin
      tick();
      if (tx_bnd_en) begin
        chk(last_fall == !pol, {rq, " boundary edge kind"}, last_fall, !pol);
        if (have_tx) begin
          chk(edge_count - last_tx_ec == 4, {rq, " boundary spacing"}, edge_count - last_tx_ec, 4);
          chk(int'(chan_idx) * 8 + int'(bit_idx) == (last_pos + 1) % 256, "R9 index step",
              int'(chan_idx) * 8 + int'(bit_idx), (last_pos + 1) % 256);
        end
        have_tx = 1; last_tx_ec = edge_count;
        last_pos = int'(chan_idx) * 8 + int'(bit_idx);
      end
      if (sample_en) begin
        chk(last_fall == pol, {rq, " sample edge kind"}, last_fall, pol);
        if (have_tx)
          chk(edge_count - last_tx_ec == 3, {rq, " sample offset"}, edge_count - last_tx_ec, 3);
      end
      if (frame_start) begin
        chk(tx_bnd_en && chan_idx == 0 && bit_idx == 0, "R9 frame origin", {chan_idx, bit_idx}, 0);
        chk(pc == 2, "R9 frame position", pc, 2);
        if (have_fs)
          chk(edge_count - last_fs_ec == 1024, "R9 frame spacing", edge_count - last_fs_ec, 1024);
        have_fs = 1; last_fs_ec = edge_count;
        tick();
        chk(frame_start == 0, "R9 one clock", frame_start, 0);
      end
      if (pol == 1 && lock_valid) chk(mode_gci == 1, "R3 mode held", mode_gci, 1);
    end
    chk(have_fs, "R9 frame seen", have_fs, 1);
  endtask

  // R8
  task automatic t_timeout();
    bit seen;
    for (int i = 0; i < 2 * FRAME_CLK; i++) begin
      tick();
      if (frame_start) break;
    end
    gen_on = 0;
    repeat (7000) tick();
    chk(lock_valid == 1, "R8 valid held before timeout", lock_valid, 1);
    repeat (2000) tick();
    chk(lock_valid == 0, "R8 valid dropped", lock_valid, 0);
    gen_on = 1;
    repeat (FRAME_CLK) tick();
    chk(lock_valid == 0, "R8 no early relock", lock_valid, 0);
    wait_valid(4 * FRAME_CLK, seen);
    chk(seen, "R8 relock", seen, 1);
  endtask

  // R6 / R7 / R10
  task automatic t_no_lock(input int space, input int width, input string tag);
    int strobes = 0;
    int vseen = 0;
    do_reset(0, space, width);
    for (int i = 0; i < 4 * FRAME_CLK; i++) begin
      tick();
      if (lock_valid) vseen++;
      if (tx_bnd_en || sample_en || frame_start) strobes++;
    end
    chk(vseen == 0, tag, vseen, 0);
    chk(strobes == 0, "R10 no strobes unlocked", strobes, 0);
  endtask

  initial begin
    t_reset();
    t_lock(0);
    t_timeout();
    t_lock(1);
    t_no_lock(500, 1, "R6 wrong spacing");
    t_no_lock(512, 6, "R7 wide pulse");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(190000 * CLK_PERIOD);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule